// File: doc/BRIEF.md
# Two-Wire Segment Data Receiver with Readback

This block is a slave on a two-wire clock/data bus of the I2C kind, with an optional latch-enable line. It runs on a fast system clock and is fed SCL and SDA inputs that are already synchronized. A transfer opens with a start condition and an address byte. The upper seven bits of that byte must equal the fixed prefix `0111` followed by the three address straps. The lowest bit chooses between writing to the block (0) and reading from it (1).

Written bits enter a 128-bit shift register. That register is copied to a 128-bit segment latch in one of two ways: automatically after every 128 data bits, or on a pulse of the enable line. In read mode the register is rotated out one bit at a time, oldest first. Because the register is rotated rather than drained, the stored segment data stays intact after a readback.

The block pulls SDA low through an open-drain enable. It changes that pull only while SCL is low.

Top module: `segdisp_slave`

## Requirements
- R1: After a start condition the first 8 bits are sent MSB first. If bits 7..1 equal {0111, addr_strap[2], addr_strap[1], addr_strap[0]}, the slave holds `sda_drive_low` high throughout the ninth SCL high phase. Bit 0 is the direction: 0 means write, 1 means read.
- R2: On an address mismatch there is no acknowledge. Every later clock is ignored until the next start condition, so `seg_latch` is unchanged and no bit is acknowledged.
- R3: In write mode every 8 data bits (MSB first) are followed by a ninth clock during which `sda_drive_low` is high.
- R4: With `latch_en` high, `seg_latch` is loaded on the 128th data bit of a write transfer and not before. The first bit received lands in `seg_latch[127]` and the last in `seg_latch[0]`.
- R5: With `latch_en` low, no automatic load occurs. A low-to-high change of `latch_en` while SCL is high copies the shift register to `seg_latch`. The same change while SCL is low does nothing.
- R6: In read mode the slave sends the stored bits oldest first. In the ninth clock of each read byte it releases SDA. A controller acknowledge (SDA low) continues the read; SDA left high ends it.
- R7: Reading is non-destructive: two consecutive 128-bit reads return the same data.
- R8: After 128 data bits and their final acknowledge clock, the next rising SCL edge is ignored, in both write and read. Data resumes on the following clock.
- R9: A stop condition ends a transfer at any point and clears the data bit count. Clocks after a stop are ignored until a start condition and a matching address arrive.
- R10: `sda_drive_low` changes only while SCL is low, and it is released on any start or stop condition.
- R11: After reset `sda_drive_low` is low and `seg_latch` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_scl | input | 1 | Synchronized bus clock |
| bus_sda | input | 1 | Synchronized bus data (wired-AND line) |
| addr_strap | input | 3 | Low three address bits |
| latch_en | input | 1 | Tied high for automatic latching, or pulsed for an external latch |
| sda_drive_low | output | 1 | Open-drain pull-down enable for SDA |
| seg_latch | output | 128 | Latched segment data |

## Verification
The hardest situation to reach is the ignored clock after 128 data bits. The bench can only observe it indirectly. It writes one full block, inserts a single clock carrying a zero, then writes a second full block. If the extra clock were shifted in, the second block would land one bit out of place in `seg_latch`. On the read side, the bench checks that the line stays released during the skipped clock and that a second full pass returns the same bytes.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int BYTE_BITS = 8;
  localparam int BIT_W     = $clog2(BYTE_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/segdisp_cond.sv
module segdisp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  // SDA edges while SCL is steadily high mark bus conditions
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/segdisp_store.sv
module segdisp_store #(
  parameter int DATA_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 rot_en,
  input  logic                 bit_in,
  input  logic                 auto_latch,
  input  logic                 ext_latch,
  output logic                 head_bit,
  output logic [DATA_BITS-1:0] disp
);
  logic [DATA_BITS-1:0] sr_q, sr_d, disp_q, disp_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en)
      sr_d = {sr_q[DATA_BITS-2:0], bit_in};
    else if (rot_en)
      sr_d = {sr_q[DATA_BITS-2:0], sr_q[DATA_BITS-1]};
    disp_d = disp_q;
    if (auto_latch || ext_latch)
      disp_d = sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      disp_q <= '0;
    end else begin
      sr_q   <= sr_d;
      disp_q <= disp_d;
    end
  end

  assign head_bit = sr_q[DATA_BITS-1];
  assign disp     = disp_q;
endmodule

// File: rtl/segdisp_ctrl.sv
module segdisp_ctrl
  import segdisp_pkg::*;
#(
  parameter int                DATA_BITS = 128,
  parameter int                PREFIX_W  = 4,
  parameter logic [PREFIX_W-1:0] PREFIX  = 4'b0111,
  parameter int                STRAP_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl,
  input  logic               sda,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic [STRAP_W-1:0] strap,
  input  logic               latch_en,
  input  logic               head_bit,
  output logic               shift_en,
  output logic               rot_en,
  output logic               auto_latch,
  output logic               ext_latch,
  output logic               sda_pull
);
  localparam int ADDR_W = PREFIX_W + STRAP_W;
  localparam int CNT_W  = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_BITS - 1);
  localparam logic [BIT_W-1:0] BYTE_END = BIT_W'(BYTE_BITS - 1);

  slv_state_e        state_q, state_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  dcnt_q, dcnt_d;
  logic              rd_q, rd_d;
  logic              full_q, full_d;
  logic              pull_q, pull_d;
  logic              len_q;

  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    addr_d     = addr_q;
    dcnt_d     = dcnt_q;
    rd_d       = rd_q;
    full_d     = full_q;
    pull_d     = pull_q;
    shift_en   = 1'b0;
    rot_en     = 1'b0;
    auto_latch = 1'b0;
    if (start_ev) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else if (scl_rise) begin
      case (state_q)
        ST_ADDR: begin
          addr_d = {addr_q[ADDR_W-2:0], sda};
          bit_d  = bit_q + BIT_W'(1);
          if (bit_q == BYTE_END) begin
            if (addr_q == {PREFIX, strap}) begin
              state_d = ST_AACK;
              rd_d    = sda;
              dcnt_d  = '0;
              full_d  = 1'b0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          state_d = rd_q ? ST_RDAT : ST_WDAT;
          bit_d   = '0;
        end
        ST_WDAT, ST_RDAT: begin
          shift_en = (state_q == ST_WDAT);
          rot_en   = (state_q == ST_RDAT);
          bit_d    = bit_q + BIT_W'(1);
          if (dcnt_q == LAST) begin
            dcnt_d     = '0;
            full_d     = 1'b1;
            auto_latch = latch_en & (state_q == ST_WDAT);
          end else begin
            dcnt_d = dcnt_q + CNT_W'(1);
          end
          if (bit_q == BYTE_END)
            state_d = (state_q == ST_WDAT) ? ST_WACK : ST_RACK;
        end
        ST_WACK: begin
          state_d = full_q ? ST_SKIP : ST_WDAT;
          bit_d   = '0;
        end
        ST_RACK: begin
          bit_d = '0;
          if (sda)
            state_d = ST_IDLE;
          else
            state_d = full_q ? ST_SKIP : ST_RDAT;
        end
        ST_SKIP: begin
          full_d  = 1'b0;
          state_d = rd_q ? ST_RDAT : ST_WDAT;
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state_q)
        ST_AACK, ST_WACK: pull_d = 1'b1;
        ST_RDAT:          pull_d = ~head_bit;
        default:          pull_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      addr_q  <= '0;
      dcnt_q  <= '0;
      rd_q    <= 1'b0;
      full_q  <= 1'b0;
      pull_q  <= 1'b0;
      len_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      addr_q  <= addr_d;
      dcnt_q  <= dcnt_d;
      rd_q    <= rd_d;
      full_q  <= full_d;
      pull_q  <= pull_d;
      len_q   <= latch_en;
    end
  end

  assign ext_latch = latch_en & ~len_q & scl;
  assign sda_pull  = pull_q;
endmodule

// File: rtl/segdisp_slave.sv
module segdisp_slave #(
  parameter int DATA_BITS = 128,
  parameter int STRAP_W   = 3,
  parameter int PREFIX_W  = 4,
  parameter logic [PREFIX_W-1:0] PREFIX = 4'b0111
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_scl,
  input  logic                 bus_sda,
  input  logic [STRAP_W-1:0]   addr_strap,
  input  logic                 latch_en,
  output logic                 sda_drive_low,
  output logic [DATA_BITS-1:0] seg_latch
);
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic shift_en, rot_en, auto_latch, ext_latch, head_bit;

  segdisp_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (bus_scl),
    .sda      (bus_sda),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  segdisp_ctrl #(
    .DATA_BITS (DATA_BITS),
    .PREFIX_W  (PREFIX_W),
    .PREFIX    (PREFIX),
    .STRAP_W   (STRAP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl        (bus_scl),
    .sda        (bus_sda),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .strap      (addr_strap),
    .latch_en   (latch_en),
    .head_bit   (head_bit),
    .shift_en   (shift_en),
    .rot_en     (rot_en),
    .auto_latch (auto_latch),
    .ext_latch  (ext_latch),
    .sda_pull   (sda_drive_low)
  );

  segdisp_store #(
    .DATA_BITS (DATA_BITS)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .rot_en     (rot_en),
    .bit_in     (bus_sda),
    .auto_latch (auto_latch),
    .ext_latch  (ext_latch),
    .head_bit   (head_bit),
    .disp       (seg_latch)
  );
endmodule

// File: rtl/segdisp_chk.sv
module segdisp_chk #(
  parameter int DATA_BITS = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_scl,
  input logic                 latch_en,
  input logic                 sda_drive_low,
  input logic [DATA_BITS-1:0] seg_latch,
  input logic                 start_ev,
  input logic                 stop_ev
);
  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low != $past(sda_drive_low)) |-> (!bus_scl && !$past(bus_scl)));

  // R10
  pull_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_drive_low);

  // R4
  latch_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_latch != $past(seg_latch)) |-> $past(bus_scl));

  // R5
  latch_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_latch != $past(seg_latch)) |-> $past(latch_en));

  // R11
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (!sda_drive_low || $isunknown(sda_drive_low));
    end
  end
endmodule

bind segdisp_slave segdisp_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_scl       (bus_scl),
  .latch_en      (latch_en),
  .sda_drive_low (sda_drive_low),
  .seg_latch     (seg_latch),
  .start_ev      (start_ev),
  .stop_ev       (stop_ev)
);

// File: tb/segdisp_slave_test.sv
module segdisp_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NB         = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic latch_en = 1'b1;
  logic sda_drive_low;
  logic [NB-1:0] seg_latch;
  logic sda_line;

  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit done = 1'b0;
  logic prev_pull = 1'b0;

  assign sda_line = m_sda & ~sda_drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  segdisp_slave uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_scl       (scl),
    .bus_sda       (sda_line),
    .addr_strap    (strap),
    .latch_en      (latch_en),
    .sda_drive_low (sda_drive_low),
    .seg_latch     (seg_latch)
  );

  // strap, address byte, expected acknowledge
  localparam logic [11:0] VEC [0:6] = '{
    {3'b101, 8'h7A, 1'b1},
    {3'b101, 8'h72, 1'b0},
    {3'b011, 8'h76, 1'b1},
    {3'b011, 8'h7E, 1'b0},
    {3'b111, 8'h7E, 1'b1},
    {3'b111, 8'hFE, 1'b0},
    {3'b001, 8'h72, 1'b1}
  };

  // R10 monitor: pull must not change while SCL is high
  always @(negedge clk) begin
    if (rst_n && (sda_drive_low !== prev_pull) && scl) viol++;
    prev_pull <= sda_drive_low;
  end

  task automatic check(input bit ok, input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b, output logic line, output logic pull_hi);
    m_sda = b;
    wait_clk(HALF);
    scl = 1'b1;
    wait_clk(HALF/2);
    line = sda_line;
    pull_hi = sda_drive_low;
    wait_clk(HALF/2);
    scl = 1'b0;
  endtask

  task automatic do_start();
    m_sda = 1'b1; wait_clk(HALF);
    scl = 1'b1;   wait_clk(HALF);
    m_sda = 1'b0; wait_clk(HALF);
    scl = 1'b0;
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wait_clk(HALF);
    scl = 1'b1;   wait_clk(HALF);
    m_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic ln, ph;
    for (int i = 7; i >= 0; i--) bit_clk(v[i], ln, ph);
    bit_clk(1'b1, ln, ph);
    ack = ph;
  endtask

  task automatic read_byte(input logic m_ack, output logic [7:0] v, output logic rel);
    logic ln, ph;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, ln, ph);
      v[i] = ln;
    end
    bit_clk(~m_ack, ln, ph);
    rel = ~ph;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 37 + seed * 91 + 5) ^ (seed << 4));
  endfunction

  function automatic logic [NB-1:0] block(input int seed);
    logic [NB-1:0] v;
    for (int i = 0; i < 16; i++) v[NB-1-8*i -: 8] = pat(seed, i);
    return v;
  endfunction

  task automatic write_block(input int seed, output int acks);
    logic a;
    acks = 0;
    for (int i = 0; i < 16; i++) begin
      send_byte(pat(seed, i), a);
      if (a) acks++;
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic a, ln, ph, rel, all_rel, all_ok;
    logic [7:0] rb;
    int acks;

    wait_clk(5);
    // R11 reset state
    check(sda_drive_low == 1'b0, "R11 pull after reset", NB'(sda_drive_low), '0);
    check(seg_latch == '0, "R11 latch after reset", seg_latch, '0);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 / R2 address table
    for (int k = 0; k < 7; k++) begin
      strap = VEC[k][11:9];
      do_start();
      send_byte(VEC[k][8:1], a);
      check(a == VEC[k][0], VEC[k][0] ? "R1 address ack" : "R2 address mismatch", NB'(a), NB'(VEC[k][0]));
      do_stop();
    end

    // R2 mismatch then a full block with automatic latch
    strap = 3'b101;
    do_start();
    send_byte(8'h7E, a);
    write_block(1, acks);
    check(acks == 0, "R2 no data ack after mismatch", NB'(acks), '0);
    check(seg_latch == '0, "R2 latch untouched after mismatch", seg_latch, '0);
    do_stop();

    // R3 / R4 write with automatic latch
    do_start();
    send_byte(8'h7A, a);
    acks = 0;
    for (int i = 0; i < 15; i++) begin
      send_byte(pat(1, i), a);
      if (a) acks++;
    end
    check(seg_latch == '0, "R4 no latch before 128 bits", seg_latch, '0);
    send_byte(pat(1, 15), a);
    if (a) acks++;
    check(acks == 16, "R3 every data byte acked", NB'(acks), NB'(16));
    check(seg_latch == block(1), "R4 latch after 128 bits", seg_latch, block(1));
    do_stop();

    // R6 / R7 / R8 read back twice
    do_start();
    send_byte(8'h7B, a);
    check(a, "R1 read address ack", NB'(a), NB'(1));
    all_ok = 1'b1; all_rel = 1'b1;
    for (int i = 0; i < 16; i++) begin
      read_byte(1'b1, rb, rel);
      if (rb != pat(1, i)) all_ok = 1'b0;
      if (!rel) all_rel = 1'b0;
    end
    check(all_ok, "R6 first read oldest first", NB'(all_ok), NB'(1));
    check(all_rel, "R6 slave releases ninth clock", NB'(all_rel), NB'(1));
    bit_clk(1'b1, ln, ph);
    check(ln == 1'b1, "R8 read skip clock released", NB'(ln), NB'(1));
    all_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      read_byte(i != 15, rb, rel);
      if (rb != pat(1, i)) all_ok = 1'b0;
    end
    check(all_ok, "R7 second read identical", NB'(all_ok), NB'(1));
    do_stop();
    check(seg_latch == block(1), "R7 latch kept after read", seg_latch, block(1));

    // R8 write skip clock
    do_start();
    send_byte(8'h7A, a);
    write_block(2, acks);
    check(seg_latch == block(2), "R8 first block latched", seg_latch, block(2));
    bit_clk(1'b0, ln, ph);
    write_block(3, acks);
    check(seg_latch == block(3), "R8 ignored clock keeps alignment", seg_latch, block(3));
    do_stop();

    // R5 external latch
    latch_en = 1'b0;
    wait_clk(2);
    do_start();
    send_byte(8'h7A, a);
    write_block(1, acks);
    check(seg_latch == block(3), "R5 no auto latch with enable low", seg_latch, block(3));
    latch_en = 1'b1; wait_clk(2);
    latch_en = 1'b0; wait_clk(2);
    check(seg_latch == block(3), "R5 enable pulse with SCL low ignored", seg_latch, block(3));
    do_stop();
    latch_en = 1'b1;
    wait_clk(3);
    check(seg_latch == block(1), "R5 enable pulse with SCL high latches", seg_latch, block(1));

    // R9 stop mid-transfer clears count
    do_start();
    send_byte(8'h7A, a);
    for (int i = 0; i < 5; i++) send_byte(8'hA5, a);
    do_stop();
    do_start();
    send_byte(8'h7A, a);
    write_block(2, acks);
    check(seg_latch == block(2), "R9 count restarts after stop", seg_latch, block(2));
    do_stop();

    // R9 clocks after stop without start are ignored
    scl = 1'b0;
    wait_clk(HALF);
    send_byte(8'h7A, a);
    check(a == 1'b0, "R9 no ack without start", NB'(a), '0);
    acks = 0;
    for (int i = 0; i < 16; i++) begin
      send_byte(8'h00, a);
      if (a) acks++;
    end
    check(acks == 0 && seg_latch == block(2), "R9 data ignored without start", seg_latch, block(2));
    scl = 1'b1;
    wait_clk(HALF);
    m_sda = 1'b1;
    wait_clk(HALF);

    // R10 pull only changes with SCL low
    check(viol == 0, "R10 pull change with SCL high", NB'(viol), '0);
    report();
  end
endmodule